// File: doc/BRIEF.md
# Cache Bus Page Mapping Engine

This block fills a small translation table. Each entry of the table maps one 64 KB virtual page of a cache bus to a physical page of external memory. A command carries several fields: a target memory code, a virtual start address, a physical start address, a page size in kilobytes, a page count and a fixed flag. The engine checks the command first. If all checks pass, it writes one table entry per clock, one for each page. When it finishes, it pulses `done` and presents a numeric status code. A separate init command sets every entry back to "invalid".

The fixed flag selects how physical pages are assigned. When it is clear, each following virtual page maps to the next physical page. When it is set, every virtual page in the run maps to the same physical page. A registered lookup port turns any virtual address into the stored target code and physical page number, so test code can see the table contents. The table has no reset, so an init command is expected after reset and before any lookup result is used.

Top module: `mmu_page_mapper`

## Requirements
- R1: After reset, `busy`, `done` and `status` are all 0.
- R2: A page size other than 64 (KB) ends the command with status 3. This check comes before every other check.
- R3: A page size of 64 with a nonzero value in the low 16 bits of either address ends with status 2. This check comes before the range check.
- R4: Status 4 is returned in three cases: the virtual address is below `VBASE`; its page index, (vaddr − VBASE) >> 16, is at or past `ENTRIES`; or index + count is above `ENTRIES`. A run that ends exactly on the last entry is accepted.
- R5: A command that passes every check returns status 0 and writes entries index .. index+count−1. A count of 0 returns status 0 and writes nothing.
- R6: With the fixed flag at 0, entry index+k holds physical page (paddr >> 16) + k.
- R7: With the fixed flag at 1, every entry in the run holds physical page paddr >> 16.
- R8: Each entry stores the 2-bit target code given with its command (0 = invalid, 1 = flash, 2 = external RAM), and the lookup port returns it.
- R9: Init writes target 0 and page 0xFFFF into every entry. A lookup of an address outside the mapped range also returns target 0 and page 0xFFFF.
- R10: A command that fails any check leaves every entry unchanged.
- R11: A command is taken when `cmd_valid` is high and `busy` is low. `done` is a one-cycle pulse that comes a set number of edges after the command is taken: 1 for an error or a count of 0, count+1 for a successful map, and `ENTRIES` for init. `busy` is high from the edge after the command is taken until `done` rises. `status` holds its value until the next `done`. A `cmd_valid` raised while `busy` is high is ignored.
- R12: The lookup outputs show the table entry for the `lk_vaddr` value present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_init | input | 1 | 1 = invalidate the whole table, 0 = map command |
| cmd_target | input | 2 | Target memory code (0 invalid, 1 flash, 2 external RAM) |
| cmd_vaddr | input | 32 | Virtual start address |
| cmd_paddr | input | 32 | Physical start address |
| cmd_psize | input | 16 | Page size in KB |
| cmd_count | input | 16 | Number of pages to map |
| cmd_fixed | input | 1 | 1 = all pages map to one physical page |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Completion code: 0, 2, 3 or 4 |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_target | output | 2 | Target code of the looked-up entry |
| lk_page | output | 16 | Physical page of the looked-up entry |

## Verification
The assertions assume that a command's fields stay constant only for the cycle in which it is taken, because the engine latches them at that point. They also assume that a command's physical page run does not wrap past the top of the 16-bit page range. The stimulus never maps past page 0xFFFF. It changes command fields only on falling edges. It holds `cmd_valid` for exactly one cycle, except in the one test that drives it on purpose while the engine is busy. The per-clock compare of lookup results starts only after the first init, because the table content before that is undefined.

// File: rtl/mmu_map_pkg.sv
package mmu_map_pkg;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_FLASH = 2'd1,
    TGT_XRAM  = 2'd2,
    TGT_RSVD  = 2'd3
  } tgt_e;

  localparam logic [2:0] ST_OK    = 3'd0;
  localparam logic [2:0] ST_ALIGN = 3'd2;
  localparam logic [2:0] ST_PSIZE = 3'd3;
  localparam logic [2:0] ST_RANGE = 3'd4;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CHECK = 2'd1,
    S_WRITE = 2'd2,
    S_INIT  = 2'd3
  } map_state_e;

endpackage

// File: rtl/mmu_arg_check.sv
module mmu_arg_check
  import mmu_map_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_SHIFT = 16,
  parameter int          PAGE_KB    = 64,
  parameter int          SZ_W       = 16,
  parameter int          CNT_W      = 16,
  parameter int          ENTRIES    = 64,
  parameter logic [31:0] VBASE      = 32'h4000_0000,
  localparam int         IDX_W      = $clog2(ENTRIES),
  localparam int         VP_W       = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [SZ_W-1:0]   psize,
  input  logic [CNT_W-1:0]  count,
  output logic [2:0]        err,
  output logic [IDX_W-1:0]  start_idx
);

  localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(VBASE);
  localparam logic [ADDR_W:0]   ENT_L  = (ADDR_W+1)'(ENTRIES);
  localparam logic [SZ_W-1:0]   PKB_L  = SZ_W'(PAGE_KB);

  logic              psize_bad, align_bad, range_bad, below;
  logic [ADDR_W-1:0] off;
  logic [VP_W-1:0]   vpage;
  logic [ADDR_W:0]   first_pg, last_pg;

  always_comb begin
    psize_bad = (psize != PKB_L);
    align_bad = (|vaddr[PAGE_SHIFT-1:0]) || (|paddr[PAGE_SHIFT-1:0]);
    below     = (vaddr < BASE_L);
    off       = vaddr - BASE_L;
    vpage     = off[ADDR_W-1:PAGE_SHIFT];
    first_pg  = (ADDR_W+1)'(vpage);
    last_pg   = first_pg + (ADDR_W+1)'(count);
    range_bad = below || (first_pg >= ENT_L) || (last_pg > ENT_L);
    start_idx = vpage[IDX_W-1:0];
    if (psize_bad)      err = ST_PSIZE;
    else if (align_bad) err = ST_ALIGN;
    else if (range_bad) err = ST_RANGE;
    else                err = ST_OK;
  end

  // R3
  order_range_chk: assert property (@(posedge clk) disable iff (rst)
    (err == ST_RANGE) |-> (psize == PKB_L && vaddr[PAGE_SHIFT-1:0] == '0 && paddr[PAGE_SHIFT-1:0] == '0));

  // R2
  order_align_chk: assert property (@(posedge clk) disable iff (rst)
    (err == ST_ALIGN) |-> (psize == PKB_L));

endmodule

// File: rtl/mmu_entry_ram.sv
module mmu_entry_ram #(
  parameter int  DEPTH = 64,
  parameter int  DW    = 18,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mmu_map_ctrl.sv
module mmu_map_ctrl
  import mmu_map_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_SHIFT = 16,
  parameter int          PAGE_KB    = 64,
  parameter int          SZ_W       = 16,
  parameter int          CNT_W      = 16,
  parameter int          PN_W       = 16,
  parameter int          ENTRIES    = 64,
  parameter logic [31:0] VBASE      = 32'h4000_0000,
  localparam int         IDX_W      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_init,
  input  logic [1:0]        cmd_target,
  input  logic [ADDR_W-1:0] cmd_vaddr,
  input  logic [ADDR_W-1:0] cmd_paddr,
  input  logic [SZ_W-1:0]   cmd_psize,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_fixed,
  output logic              busy,
  output logic              done,
  output logic [2:0]        status,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [1:0]        wr_target,
  output logic [PN_W-1:0]   wr_page
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  map_state_e        state;
  tgt_e              tgt_q;
  logic [ADDR_W-1:0] vaddr_q, paddr_q;
  logic [SZ_W-1:0]   psize_q;
  logic [CNT_W-1:0]  cnt_q, left_q;
  logic              fixed_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PN_W-1:0]   page_q;
  logic [2:0]        chk_err;
  logic [IDX_W-1:0]  chk_idx;

  mmu_arg_check #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_KB(PAGE_KB),
    .SZ_W(SZ_W), .CNT_W(CNT_W), .ENTRIES(ENTRIES), .VBASE(VBASE)
  ) u_check (
    .clk(clk), .rst(rst),
    .vaddr(vaddr_q), .paddr(paddr_q), .psize(psize_q), .count(cnt_q),
    .err(chk_err), .start_idx(chk_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      status  <= ST_OK;
      tgt_q   <= TGT_NONE;
      vaddr_q <= '0;
      paddr_q <= '0;
      psize_q <= '0;
      cnt_q   <= '0;
      left_q  <= '0;
      fixed_q <= 1'b0;
      idx_q   <= '0;
      page_q  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            tgt_q   <= tgt_e'(cmd_target);
            vaddr_q <= cmd_vaddr;
            paddr_q <= cmd_paddr;
            psize_q <= cmd_psize;
            cnt_q   <= cmd_count;
            fixed_q <= cmd_fixed;
            idx_q   <= '0;
            state   <= cmd_init ? S_INIT : S_CHECK;
          end
        end
        S_CHECK: begin
          if (chk_err != ST_OK || cnt_q == '0) begin
            done   <= 1'b1;
            status <= chk_err;
            state  <= S_IDLE;
          end else begin
            idx_q  <= chk_idx;
            left_q <= cnt_q;
            page_q <= paddr_q[PAGE_SHIFT+PN_W-1:PAGE_SHIFT];
            state  <= S_WRITE;
          end
        end
        S_WRITE: begin
          idx_q  <= idx_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (!fixed_q) page_q <= page_q + 1'b1;
          if (left_q == CNT_W'(1)) begin
            done   <= 1'b1;
            status <= ST_OK;
            state  <= S_IDLE;
          end
        end
        S_INIT: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) begin
            done   <= 1'b1;
            status <= ST_OK;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != S_IDLE);
    wr_en     = (state == S_WRITE) || (state == S_INIT);
    wr_idx    = idx_q;
    wr_target = (state == S_INIT) ? TGT_NONE : tgt_q;
    wr_page   = (state == S_INIT) ? '1 : page_q;
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  no_write_on_err_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHECK && chk_err != ST_OK) |=> !wr_en);

  // R6
  incr_page_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_WRITE && $past(state == S_WRITE) && !fixed_q)
      |-> (wr_page == $past(wr_page) + 1'b1 && wr_idx == $past(wr_idx) + 1'b1));

  // R7
  fixed_page_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_WRITE && $past(state == S_WRITE) && fixed_q) |-> $stable(wr_page));

  // R9
  init_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_INIT) |-> (wr_en && wr_target == TGT_NONE && wr_page == '1));

  // R2
  status_legal_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (status == ST_OK || status == ST_ALIGN || status == ST_PSIZE || status == ST_RANGE));

endmodule

// File: rtl/mmu_page_mapper.sv
module mmu_page_mapper
  import mmu_map_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_SHIFT = 16,
  parameter int          PAGE_KB    = 64,
  parameter int          SZ_W       = 16,
  parameter int          CNT_W      = 16,
  parameter int          PN_W       = 16,
  parameter int          ENTRIES    = 64,
  parameter logic [31:0] VBASE      = 32'h4000_0000,
  localparam int         IDX_W      = $clog2(ENTRIES),
  localparam int         ENT_W      = PN_W + 2,
  localparam int         VP_W       = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_init,
  input  logic [1:0]        cmd_target,
  input  logic [ADDR_W-1:0] cmd_vaddr,
  input  logic [ADDR_W-1:0] cmd_paddr,
  input  logic [SZ_W-1:0]   cmd_psize,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_fixed,
  output logic              busy,
  output logic              done,
  output logic [2:0]        status,
  input  logic [ADDR_W-1:0] lk_vaddr,
  output logic [1:0]        lk_target,
  output logic [PN_W-1:0]   lk_page
);

  localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(VBASE);
  localparam logic [VP_W-1:0]   ENT_VP = VP_W'(ENTRIES);

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [1:0]       wr_target;
  logic [PN_W-1:0]  wr_page;
  logic [ENT_W-1:0] rd_data;

  logic [ADDR_W-1:0] lk_off;
  logic [VP_W-1:0]   lk_vp;
  logic              lk_in;
  logic              lk_in_q;

  mmu_map_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_KB(PAGE_KB), .SZ_W(SZ_W),
    .CNT_W(CNT_W), .PN_W(PN_W), .ENTRIES(ENTRIES), .VBASE(VBASE)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_init(cmd_init), .cmd_target(cmd_target),
    .cmd_vaddr(cmd_vaddr), .cmd_paddr(cmd_paddr), .cmd_psize(cmd_psize),
    .cmd_count(cmd_count), .cmd_fixed(cmd_fixed),
    .busy(busy), .done(done), .status(status),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_target(wr_target), .wr_page(wr_page)
  );

  always_comb begin
    lk_off = lk_vaddr - BASE_L;
    lk_vp  = lk_off[ADDR_W-1:PAGE_SHIFT];
    lk_in  = (lk_vaddr >= BASE_L) && (lk_vp < ENT_VP);
  end

  mmu_entry_ram #(.DEPTH(ENTRIES), .DW(ENT_W)) u_ram (
    .clk(clk),
    .we(wr_en), .waddr(wr_idx), .wdata({wr_target, wr_page}),
    .raddr(lk_vp[IDX_W-1:0]), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) lk_in_q <= 1'b0;
    else     lk_in_q <= lk_in;
  end

  always_comb begin
    lk_target = lk_in_q ? rd_data[ENT_W-1:PN_W] : TGT_NONE;
    lk_page   = lk_in_q ? rd_data[PN_W-1:0]     : '1;
  end

  // R9
  outside_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_in_q |-> (lk_target == TGT_NONE && lk_page == '1));

  // R11
  write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (busy && !done));

endmodule

// File: tb/mmu_page_mapper_tb.sv
module mmu_page_mapper_tb;

  localparam int      ENT   = 64;
  localparam longint  VB    = 64'h4000_0000;
  localparam longint  PG    = 65536;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_init = 1'b0, cmd_fixed = 1'b0;
  logic [1:0]  cmd_target = 2'd0;
  logic [31:0] cmd_vaddr = '0, cmd_paddr = '0, lk_vaddr = '0;
  logic [15:0] cmd_psize = '0, cmd_count = '0;
  logic        busy, done;
  logic [2:0]  status;
  logic [1:0]  lk_target;
  logic [15:0] lk_page;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  mmu_page_mapper u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_init(cmd_init),
    .cmd_target(cmd_target), .cmd_vaddr(cmd_vaddr), .cmd_paddr(cmd_paddr),
    .cmd_psize(cmd_psize), .cmd_count(cmd_count), .cmd_fixed(cmd_fixed),
    .busy(busy), .done(done), .status(status),
    .lk_vaddr(lk_vaddr), .lk_target(lk_target), .lk_page(lk_page)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // reference model
  int     m_tgt [ENT];
  int     m_pg  [ENT];
  int     rem = 0, e_status = 0, p_status = 0, p_tgt = 0, p_pg = 0, p_idx = 0, p_cnt = 0;
  bit     e_done = 0, inited = 0, lk_ok = 0, p_init = 0, p_fixed = 0;
  int     e_lt = 0, e_lp = 0;

  function automatic int calc_status(longint va, longint pa, int ps, int cnt);
    longint vp;
    if (ps != 64) return 3;
    if ((va % PG) != 0 || (pa % PG) != 0) return 2;
    if (va < VB) return 4;
    vp = (va - VB) / PG;
    if (vp >= ENT || vp + cnt > ENT) return 4;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rem = 0; e_done = 0; e_status = 0; inited = 0; lk_ok = 0;
    end else begin
      longint lva;
      lva   = longint'(lk_vaddr);
      lk_ok = inited && (rem == 0);
      if (lva < VB || (lva - VB) / PG >= ENT) begin
        e_lt = 0; e_lp = 'hFFFF;
      end else begin
        e_lt = m_tgt[int'((lva - VB) / PG)];
        e_lp = m_pg[int'((lva - VB) / PG)];
      end
      e_done = 0;
      if (rem > 0) begin
        rem--;
        if (rem == 0) begin
          e_done = 1;
          e_status = p_status;
          if (p_init) begin
            for (int i = 0; i < ENT; i++) begin m_tgt[i] = 0; m_pg[i] = 'hFFFF; end
            inited = 1;
          end else if (p_status == 0) begin
            for (int k = 0; k < p_cnt; k++) begin
              m_tgt[p_idx + k] = p_tgt;
              m_pg[p_idx + k]  = p_fixed ? p_pg : ((p_pg + k) & 'hFFFF);
            end
          end
        end
      end else if (cmd_valid) begin
        p_init = cmd_init;
        if (cmd_init) begin
          p_status = 0; rem = ENT;
        end else begin
          p_status = calc_status(longint'(cmd_vaddr), longint'(cmd_paddr),
                                 int'(cmd_psize), int'(cmd_count));
          p_tgt   = int'(cmd_target);
          p_pg    = int'(cmd_paddr[31:16]);
          p_fixed = cmd_fixed;
          p_cnt   = int'(cmd_count);
          p_idx   = (p_status == 0) ? int'((longint'(cmd_vaddr) - VB) / PG) : 0;
          rem     = (p_status != 0 || p_cnt == 0) ? 1 : p_cnt + 1;
        end
      end
    end
  end

  // per-clock compare
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      // R11
      chk(busy == (rem > 0), "R11 busy", busy, rem > 0);
      chk(done == e_done, "R11 done", done, e_done);
      chk(status == 3'(e_status), "R11 status", status, e_status);
      if (lk_ok) begin
        // R12
        chk(lk_target == 2'(e_lt), "R12 lk_target", lk_target, e_lt);
        chk(lk_page == 16'(e_lp), "R12 lk_page", lk_page, e_lp);
      end
    end
  end

  initial begin
    while (cyc < 100000) @(negedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic run_cmd(input bit init, input int tgt, input longint va, input longint pa,
                         input int ps, input int cnt, input bit fx, input int exp_st,
                         input string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_init = init; cmd_target = 2'(tgt);
    cmd_vaddr = 32'(va); cmd_paddr = 32'(pa); cmd_psize = 16'(ps);
    cmd_count = 16'(cnt); cmd_fixed = fx;
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
    chk(status == 3'(exp_st), tag, status, exp_st);
  endtask

  task automatic look(input longint va, input int et, input int ep, input string tag);
    @(negedge clk);
    lk_vaddr = 32'(va);
    @(negedge clk);
    @(negedge clk);
    chk(lk_target == 2'(et) && lk_page == 16'(ep), tag, {lk_target, lk_page}, {2'(et), 16'(ep)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 0 && done == 0 && status == 0, "R1 reset outputs", {busy, done, status}, 0);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && status == 0, "R1 after reset", {busy, done, status}, 0);

    // R9 init
    run_cmd(1, 0, 0, 0, 0, 0, 0, 0, "R9 init status");
    look(VB + 5 * PG, 0, 'hFFFF, "R9 entry invalid after init");
    look(VB + 63 * PG, 0, 'hFFFF, "R9 last entry invalid");
    look(VB - PG, 0, 'hFFFF, "R9 lookup below range");
    look(VB + 64 * PG, 0, 'hFFFF, "R9 lookup above range");

    // R5 R6 R8 flash consecutive
    run_cmd(0, 1, VB + 2 * PG, 64'h0030_0000, 64, 4, 0, 0, "R5 map flash ok");
    look(VB + 2 * PG, 1, 'h30, "R6 first page");
    look(VB + 5 * PG + 'h1234, 1, 'h33, "R6 last page with offset");
    look(VB + 6 * PG, 0, 'hFFFF, "R5 entry past run untouched");

    // R7 R8 external RAM fixed
    run_cmd(0, 2, VB + 10 * PG, 64'h0080_0000, 64, 3, 1, 0, "R7 map xram fixed ok");
    look(VB + 10 * PG, 2, 'h80, "R7 first fixed page");
    look(VB + 12 * PG, 2, 'h80, "R7 third fixed page");
    look(VB + 11 * PG, 2, 'h80, "R8 xram target");

    // R2 precedence, R10
    run_cmd(0, 1, VB + 10 * PG + 4, 64'h0000_0001, 32, 1, 0, 3, "R2 bad page size wins");
    look(VB + 10 * PG, 2, 'h80, "R10 unchanged after size error");

    // R3
    run_cmd(0, 1, VB + 20 * PG + 'h100, 64'h0010_0000, 64, 1, 0, 2, "R3 misaligned vaddr");
    run_cmd(0, 1, VB - PG, 64'h0010_0800, 64, 1, 0, 2, "R3 misaligned paddr before range");

    // R4
    run_cmd(0, 1, VB - PG, 64'h0010_0000, 64, 1, 0, 4, "R4 below base");
    run_cmd(0, 1, VB + 64 * PG, 64'h0010_0000, 64, 1, 0, 4, "R4 at end of range");
    run_cmd(0, 1, VB + 62 * PG, 64'h0010_0000, 64, 4, 0, 4, "R4 run past table");
    look(VB + 62 * PG, 0, 'hFFFF, "R10 unchanged after range error");
    run_cmd(0, 1, VB + 60 * PG, 64'h0040_0000, 64, 4, 0, 0, "R4 run ending on last entry");
    look(VB + 63 * PG, 1, 'h43, "R4 last entry written");

    // R5 count zero
    run_cmd(0, 2, VB + 40 * PG, 64'h0050_0000, 64, 0, 0, 0, "R5 zero count ok");
    look(VB + 40 * PG, 0, 'hFFFF, "R5 zero count writes nothing");

    // R11 command while busy ignored
    @(negedge clk);
    cmd_valid = 1; cmd_init = 0; cmd_target = 2'd1; cmd_vaddr = 32'(VB + 30 * PG);
    cmd_paddr = 32'h0060_0000; cmd_psize = 16'd64; cmd_count = 16'd4; cmd_fixed = 0;
    @(negedge clk);
    cmd_vaddr = 32'(VB + 20 * PG); cmd_target = 2'd2;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
    chk(status == 0, "R11 busy command status", status, 0);
    look(VB + 20 * PG, 0, 'hFFFF, "R11 command during busy ignored");
    look(VB + 33 * PG, 1, 'h63, "R11 first command completed");

    // R8 invalid target stored
    run_cmd(0, 0, VB + 45 * PG, 64'h0070_0000, 64, 1, 0, 0, "R8 map invalid target");
    look(VB + 45 * PG, 0, 'h70, "R8 invalid target kept");

    // R9 re-init
    run_cmd(1, 0, 0, 0, 0, 0, 0, 0, "R9 second init");
    look(VB + 2 * PG, 0, 'hFFFF, "R9 mapped entry cleared");
    look(VB + 10 * PG, 0, 'hFFFF, "R9 fixed entry cleared");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule